// File: doc/BRIEF.md
# Output-Compare Timer

This block is a 16-bit counter that advances freely on a selectable division of the clock, with five output-compare channels watching it. Each channel holds a 16-bit compare value. When the counter takes that value, the channel raises its flag and performs a pin action. Channels two to five each own one output pin. The first channel owns no pin of its own: it writes a data pattern onto any subset of the other four pins, chosen by a mask.

Software can raise any channel's pin action at will through a force strobe, and that action leaves the flag alone. Flags are cleared by writing ones. Each flag, together with a counter wrap flag, reaches an interrupt line when its enable bit is set.

Register map (4-bit address, 16-bit data, write on `bus_wr`, read data registered one cycle after the address): 0 counter (read only), 1 prescale select (bits 1:0), 2 force strobes (bit i = channel i+1, reads 0), 3 action codes (bits 2j+1:2j for the channel driving pin j), 4 master mask (bit j = pin j), 5 master data (bit j = pin j), 6 flags (bits 4:0 = channels 1..5, bit 5 = wrap), 7 interrupt enables (same layout as flags), 8 to 12 compare values of channels 1 to 5.

Top module: `oc_timer`

## Requirements
- R1: The counter resets to 0 and advances by one on each prescaled tick; select values 0, 1, 2 and 3 give one tick every 1, 4, 8 and 16 clocks, so any 64 consecutive clocks hold 64, 16, 8 or 4 ticks.
- R2: The wrap flag (flag bit 5) is set on the edge where the counter goes from 0xFFFF to 0x0000.
- R3: A channel's flag is set, and its pin action is taken, on the same edge where the counter takes that channel's compare value.
- R4: Writing a 1 to force bit i performs channel i+1's pin action on that write edge and does not set its flag.
- R5: Action codes for pins 0 to 3 (driven by channels 2 to 5): 0 leaves the pin unchanged, 1 toggles it, 2 drives it low, 3 drives it high; all pins reset to 0.
- R6: `irq_cmp[i]` is high exactly while flag bit i and enable bit i are both 1; `irq_ovf` is the same for bit 5.
- R7: Writing a 1 to a flag bit clears it; a set and a clear of the same bit on the same edge leave it set.
- R8: The prescale select is written only during the first 64 clocks after reset; later writes leave it and the tick rate unchanged.
- R9: On a channel-1 event (match or force), every pin whose mask bit is 1 takes its data bit, overriding any other channel's action on that pin in the same cycle.
- R10: Compare values reset to 0xFFFF; flags, enables, action codes, mask and data reset to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data for the address of the previous cycle |
| oc_pin | output | 4 | Compare output pins, pin j driven by channel j+2 and the master pattern |
| irq_cmp | output | 5 | Per-channel interrupt requests |
| irq_ovf | output | 1 | Counter wrap interrupt request |

## Verification
Two collisions matter: channel 1 and another channel acting on the same pin in one cycle, and a compare match landing on the same edge as a software write-one clear of that flag. The first is provoked by giving channel 1 and channel 4 equal compare values with opposing pin intents; the pin must end at the master data bit. The second is provoked by timing a flag-clear write, from the polled counter value, onto the exact match edge; the flag must read back as set. Exact edge placement of matches and wrap is judged by polling the counter and checking the pin and interrupt one poll before and at the match.

// File: rtl/oc_timer_pkg.sv
package oc_timer_pkg;

  typedef enum logic [3:0] {
    A_CNT   = 4'd0,
    A_PRE   = 4'd1,
    A_FORCE = 4'd2,
    A_ACT   = 4'd3,
    A_MASK  = 4'd4,
    A_DATA  = 4'd5,
    A_FLAG  = 4'd6,
    A_IEN   = 4'd7,
    A_CMP0  = 4'd8
  } reg_addr_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_TOGGLE = 2'd1,
    ACT_LOW    = 2'd2,
    ACT_HIGH   = 2'd3
  } pin_act_e;

endpackage

// File: rtl/oc_timebase.sv
module oc_timebase #(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned LOCK_CYC = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_wr,
  input  logic [1:0]       sel_wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic [1:0]       sel_q,
  output logic             tick,
  output logic             wrap,
  output logic             lock_open
);
  localparam int unsigned LOCK_W = $clog2(LOCK_CYC + 1);

  logic [3:0]        div_q;
  logic [LOCK_W-1:0] lock_q;

  assign lock_open = (lock_q < LOCK_W'(LOCK_CYC));

  always_comb begin
    case (sel_q)
      2'd0:    tick = 1'b1;
      2'd1:    tick = (div_q[1:0] == 2'b11);
      2'd2:    tick = (div_q[2:0] == 3'b111);
      default: tick = (div_q == 4'hF);
    endcase
  end

  assign wrap = tick && (cnt_q == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      lock_q <= '0;
      sel_q  <= '0;
      cnt_q  <= '0;
    end else begin
      div_q <= div_q + 4'd1;
      if (lock_open) lock_q <= lock_q + LOCK_W'(1);
      if (sel_wr && lock_open) sel_q <= sel_wdata;
      if (tick) cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/oc_cmp_chan.sv
module oc_cmp_chan #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt_nxt,
  output logic [CNT_W-1:0] cmp_q,
  output logic             hit
);
  assign hit = tick && (cnt_nxt == cmp_q);

  always_ff @(posedge clk) begin
    if (rst)     cmp_q <= '1;
    else if (wr) cmp_q <= wdata;
  end
endmodule

// File: rtl/oc_pin_unit.sv
module oc_pin_unit
  import oc_timer_pkg::*;
#(
  parameter int unsigned NPIN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPIN:0]     ev,
  input  logic [2*NPIN-1:0] act,
  input  logic [NPIN-1:0]   mask,
  input  logic [NPIN-1:0]   data,
  output logic [NPIN-1:0]   pin_q
);
  logic [NPIN-1:0] pin_nxt;

  always_comb begin
    pin_nxt = pin_q;
    for (int j = 0; j < int'(NPIN); j++) begin
      if (ev[j+1]) begin
        case (pin_act_e'(act[2*j +: 2]))
          ACT_TOGGLE: pin_nxt[j] = ~pin_q[j];
          ACT_LOW:    pin_nxt[j] = 1'b0;
          ACT_HIGH:   pin_nxt[j] = 1'b1;
          default:    pin_nxt[j] = pin_q[j];
        endcase
      end
      // master channel overrides the per-pin channel
      if (ev[0] && mask[j]) pin_nxt[j] = data[j];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pin_q <= '0;
    else     pin_q <= pin_nxt;
  end
endmodule

// File: rtl/oc_timer.sv
module oc_timer
  import oc_timer_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned NUM_CH   = 5,
  parameter int unsigned LOCK_CYC = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [3:0]        bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [NUM_CH-2:0] oc_pin,
  output logic [NUM_CH-1:0] irq_cmp,
  output logic              irq_ovf
);
  localparam int unsigned NPIN   = NUM_CH - 1;
  localparam int unsigned FLAG_W = NUM_CH + 1;
  localparam int unsigned ACT_W  = 2 * NPIN;

  logic [CNT_W-1:0]  cnt_q;
  logic [1:0]        sel_q;
  logic              tick, wrap, lock_open;
  logic [CNT_W-1:0]  cmp_q [NUM_CH];
  logic [NUM_CH-1:0] hit, force_s, ev;
  logic [FLAG_W-1:0] flag_q, ien_q, flag_clr;
  logic [ACT_W-1:0]  act_q;
  logic [NPIN-1:0]   mask_q, data_q;
  logic [CNT_W-1:0]  rd_mux;

  oc_timebase #(.CNT_W(CNT_W), .LOCK_CYC(LOCK_CYC)) u_tb (
    .clk(clk), .rst(rst),
    .sel_wr(bus_wr && (bus_addr == A_PRE)),
    .sel_wdata(bus_wdata[1:0]),
    .cnt_q(cnt_q), .sel_q(sel_q), .tick(tick), .wrap(wrap),
    .lock_open(lock_open)
  );

  for (genvar k = 0; k < int'(NUM_CH); k++) begin : g_ch
    oc_cmp_chan #(.CNT_W(CNT_W)) u_cmp (
      .clk(clk), .rst(rst),
      .wr(bus_wr && (bus_addr == 4'(int'(A_CMP0) + k))),
      .wdata(bus_wdata), .tick(tick),
      .cnt_nxt(cnt_q + CNT_W'(1)),
      .cmp_q(cmp_q[k]), .hit(hit[k])
    );
  end

  assign force_s  = (bus_wr && (bus_addr == A_FORCE)) ? bus_wdata[NUM_CH-1:0] : '0;
  assign flag_clr = (bus_wr && (bus_addr == A_FLAG))  ? bus_wdata[FLAG_W-1:0] : '0;
  assign ev       = hit | force_s;

  oc_pin_unit #(.NPIN(NPIN)) u_pin (
    .clk(clk), .rst(rst), .ev(ev), .act(act_q),
    .mask(mask_q), .data(data_q), .pin_q(oc_pin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= '0;
      mask_q <= '0;
      data_q <= '0;
      ien_q  <= '0;
      flag_q <= '0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          A_ACT:   act_q  <= bus_wdata[ACT_W-1:0];
          A_MASK:  mask_q <= bus_wdata[NPIN-1:0];
          A_DATA:  data_q <= bus_wdata[NPIN-1:0];
          A_IEN:   ien_q  <= bus_wdata[FLAG_W-1:0];
          default: ;
        endcase
      end
      // a set on the same edge beats a write-one clear
      flag_q <= (flag_q & ~flag_clr) | {wrap, hit};
    end
  end

  assign irq_cmp = flag_q[NUM_CH-1:0] & ien_q[NUM_CH-1:0];
  assign irq_ovf = flag_q[NUM_CH] & ien_q[NUM_CH];

  always_comb begin
    case (bus_addr)
      A_CNT:   rd_mux = cnt_q;
      A_PRE:   rd_mux = CNT_W'(sel_q);
      A_ACT:   rd_mux = CNT_W'(act_q);
      A_MASK:  rd_mux = CNT_W'(mask_q);
      A_DATA:  rd_mux = CNT_W'(data_q);
      A_FLAG:  rd_mux = CNT_W'(flag_q);
      A_IEN:   rd_mux = CNT_W'(ien_q);
      default: rd_mux = '0;
    endcase
    for (int k = 0; k < int'(NUM_CH); k++) begin
      if (bus_addr == 4'(int'(A_CMP0) + k)) rd_mux = cmp_q[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/oc_timer_chk.sv
module oc_timer_chk
  import oc_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NUM_CH = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [3:0]        bus_addr,
  input logic              tick,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [1:0]        sel_q,
  input logic              lock_open,
  input logic [NUM_CH-1:0] hit,
  input logic [NUM_CH-1:0] force_s,
  input logic [NUM_CH-1:0] ev,
  input logic [NUM_CH:0]   flag_q,
  input logic [NUM_CH-2:0] mask_q,
  input logic [NUM_CH-2:0] data_q,
  input logic [NUM_CH-2:0] oc_pin
);
  assert_cnt_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q));

  assert_cnt_step_R1: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  assert_wrap_flag_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && (cnt_q == {CNT_W{1'b1}})) |=> flag_q[NUM_CH]);

  assert_hit_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (|hit) |=> ((flag_q[NUM_CH-1:0] & $past(hit)) == $past(hit)));

  assert_force_noflag_R4: assert property (@(posedge clk) disable iff (rst)
    (|(force_s & ~hit & ~flag_q[NUM_CH-1:0]))
      |=> ((flag_q[NUM_CH-1:0] & $past(force_s & ~hit & ~flag_q[NUM_CH-1:0])) == '0));

  assert_sel_locked_R8: assert property (@(posedge clk) disable iff (rst)
    (!lock_open && bus_wr && (bus_addr == A_PRE)) |=> $stable(sel_q));

  assert_master_wins_R9: assert property (@(posedge clk) disable iff (rst)
    ev[0] |=> (((oc_pin ^ $past(data_q)) & $past(mask_q)) == '0));
endmodule

bind oc_timer oc_timer_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .tick(tick), .cnt_q(cnt_q), .sel_q(sel_q), .lock_open(lock_open),
  .hit(hit), .force_s(force_s), .ev(ev), .flag_q(flag_q),
  .mask_q(mask_q), .data_q(data_q), .oc_pin(oc_pin)
);

// File: tb/test_oc_timer.sv
module test_oc_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic [3:0]  oc_pin;
  logic [4:0]  irq_cmp;
  logic        irq_ovf;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  oc_timer i_oc_timer (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .oc_pin(oc_pin),
    .irq_cmp(irq_cmp), .irq_ovf(irq_ovf)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bus_wr = 1'b0; bus_addr = 4'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 4'd0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_addr = 4'd0;
  endtask

  // address 0 selected; returns at the negedge where the registered read shows v
  task automatic wait_cnt(input logic [15:0] v);
    int n = 0;
    @(negedge clk);
    while (bus_rdata != v && n < 70000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] a, b, d;
    logic s, e;

    // R10: reset state
    do_reset();
    rd(4'd6, d);  check("R10 flags after reset", d, 0);
    rd(4'd8, d);  check("R10 compare after reset", d, 16'hFFFF);
    rd(4'd4, d);  check("R10 mask after reset", d, 0);
    check("R5 pins after reset", oc_pin, 0);
    check("R6 irq after reset", {irq_ovf, irq_cmp}, 0);

    // R1 / R8: prescale sweep, lock window
    for (int sel = 0; sel < 4; sel++) begin
      do_reset();
      wr(4'd1, 16'(sel));
      rd(4'd1, d); check("R8 select written in window", d, sel);
      @(negedge clk); a = bus_rdata;
      repeat (64) @(negedge clk);
      b = bus_rdata;
      check("R1 ticks in 64 clocks", 16'(b - a), 64 >> (sel == 0 ? 0 : sel + 1));
      wr(4'd1, 16'((sel + 1) % 4));
      rd(4'd1, d); check("R8 select locked", d, sel);
      @(negedge clk); a = bus_rdata;
      repeat (64) @(negedge clk);
      b = bus_rdata;
      check("R8 rate unchanged after late write", 16'(b - a), 64 >> (sel == 0 ? 0 : sel + 1));
    end

    // R5 / R4: action code sweep through force strobes
    do_reset();
    for (int j = 0; j < 4; j++) begin
      for (int code = 0; code < 4; code++) begin
        for (int st = 0; st < 2; st++) begin
          s = st[0];
          wr(4'd3, 16'((s ? 3 : 2) << (2 * j)));
          wr(4'd2, 16'(1 << (j + 1)));
          wr(4'd3, 16'(code << (2 * j)));
          wr(4'd2, 16'(1 << (j + 1)));
          case (code)
            0: e = s;
            1: e = ~s;
            2: e = 1'b0;
            default: e = 1'b1;
          endcase
          check($sformatf("R5 pin%0d code%0d from %0d", j, code, st), oc_pin[j], e);
        end
      end
    end
    rd(4'd6, d); check("R4 force leaves flags clear", d, 0);

    // R3 / R6: match edge placement, channel 3 toggles pin 1
    do_reset();
    wr(4'd3, 16'h0004);
    wr(4'd7, 16'h0004);
    wr(4'd10, 16'd300);
    wait_cnt(16'd298);
    check("R3 pin before match", oc_pin[1], 0);
    check("R6 irq before match", irq_cmp, 0);
    @(negedge clk);
    check("R3 pin at match", oc_pin[1], 1);
    check("R6 irq at match", irq_cmp, 5'b00100);
    // R7: write-one clear
    wr(4'd6, 16'h0004);
    rd(4'd6, d); check("R7 flag cleared", d, 0);
    check("R6 irq drops with flag", irq_cmp, 0);

    // R7: set wins over clear on the same edge (channel 1 at 500)
    wr(4'd8, 16'd500);
    wait_cnt(16'd498);
    bus_wr = 1'b1; bus_addr = 4'd6; bus_wdata = 16'h0001;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 4'd0;
    rd(4'd6, d); check("R7 set beats clear", d[0], 1);

    // R9: master overrides channel 4 on a shared match
    do_reset();
    wr(4'd3, 16'h0030);
    wr(4'd4, 16'h0005);
    wr(4'd5, 16'h0001);
    wr(4'd8, 16'd200);
    wr(4'd11, 16'd200);
    wait_cnt(16'd199);
    check("R9 master data on pin0", oc_pin[0], 1);
    check("R9 master beats high on pin2", oc_pin[2], 0);
    wr(4'd6, 16'h003F);
    wr(4'd5, 16'h0004);
    wr(4'd2, 16'h0001);
    check("R9 forced master pattern", oc_pin, 4'b0100);
    rd(4'd6, d); check("R4 master force leaves flag", d[0], 0);

    // R2: wrap flag
    do_reset();
    wr(4'd7, 16'h0020);
    wait_cnt(16'hFFFE);
    check("R2 no wrap before", irq_ovf, 0);
    @(negedge clk);
    check("R2 wrap flag at FFFF to 0", irq_ovf, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule